// File: doc/BRIEF.md
# Interleaved Result Multiplexer and Formatter

This block sits behind a bank of parallel converter sections that take turns sampling one analog input. Each section finishes its conversion some cycles after it samples, and then raises a transfer strobe for one clock while it presents a 9-bit result. The block runs a modulo-16 rotation pointer and selects one section per clock. It also publishes a one-hot phase vector that tells the bank which section samples in the current cycle. The rotation is set so that every section hands over its result 11 cycles after it sampled. The output register then adds the twelfth cycle.

The selected result is formatted before it is registered. If the top bit of the result is set, the word is an overrange and leaves as all ones on all nine bits. Otherwise the low eight bits leave unchanged as a straight binary code, with bit 8 clear. A data-valid strobe marks each cycle in which a new word was captured. The output bus is modelled as data plus a drive-enable that follows an active-low enable input. Reset is asynchronous and active low, and the caller must release it in step with the clock.

Top module: `irm_result_merge`

## Requirements
- R1: While reset is asserted, `dout` is 0 and `dval` is 0. In the first cycle after release, `smp_phase` has only bit 11 set.
- R2: `smp_phase` is one-hot in every cycle after reset and rotates up by one position per clock, wrapping from bit 15 to bit 0.
- R3: A word placed in the section that `smp_phase` named in cycle t, and strobed by that section when it is selected, is on `dout` with `dval` high in cycle t+12.
- R4: In cycles 1 to 11 after reset release, `dval` stays 0 and `dout` stays 0, whatever the transfer strobes do. The first accepted transfer is the one in cycle 11.
- R5: In a cycle where the selected section does not strobe, the next cycle shows `dval` = 0 and `dout` unchanged.
- R6: Strobes from sections that are not selected have no effect on `dout` or `dval`.
- R7: A result with bit 8 = 0 leaves as bit 8 = 0 and bits 7..0 equal to the result's bits 7..0.
- R8: A result with bit 8 = 1 leaves as 9'h1FF, whatever its low bits are.
- R9: `dout_drive` equals the inverse of `oe_n` with no clock delay. `oe_n` has no effect on `dout` or `dval`.
- R10: The selected section index is 0 in the first cycle after reset. It advances by one each clock and goes from 15 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| oe_n | input | 1 | Active-low output enable for the data bus |
| sec_res | input | 144 | Results of the 16 sections; section i sits in bits 9i+8..9i |
| sec_xfer | input | 16 | Transfer strobe of each section, bit i for section i |
| smp_phase | output | 16 | One-hot mark of the section that samples this cycle |
| dout | output | 9 | Registered word; bit 8 is the overrange flag, bits 7..0 the code |
| dout_drive | output | 1 | High when the data bus is driven, low for high impedance |
| dval | output | 1 | High for one cycle with each new word on `dout` |

## Verification
A wrong rotation pointer shows up one clock later as a phase vector that no longer steps by one bit. Every word after that comes from the wrong section. Against per-section distinct values, this is visible on the first strobed cycle that follows. A warm-up counter that is off by one shows a `dval` pulse in cycle 11 or misses the one in cycle 12. A formatter or hold fault shows on the very next word, or on the next cycle without a strobe.

// File: rtl/irm_pkg.sv
`timescale 1ns/1ps
package irm_pkg;
  localparam int IRM_SECTIONS = 16;
  localparam int IRM_RES_W    = 9;
  localparam int IRM_LATENCY  = 12;
endpackage

// File: rtl/irm_phase_gen.sv
`timescale 1ns/1ps
module irm_phase_gen #(
  parameter  int NSEC = irm_pkg::IRM_SECTIONS,
  parameter  int LEAD = irm_pkg::IRM_LATENCY - 1,
  localparam int IDXW = $clog2(NSEC),
  localparam int WCW  = $clog2(LEAD + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [IDXW-1:0] sel_idx,
  output logic            primed,
  output logic [NSEC-1:0] smp_onehot
);
  logic [IDXW-1:0] sel_d;
  logic [WCW-1:0]  warm_q, warm_d;
  logic            warm_en;
  logic [IDXW:0]   samp_sum;
  logic [IDXW-1:0] samp_idx;

  // rotation pointer and warm-up counter: next state
  always_comb begin
    sel_d   = (sel_idx == IDXW'(NSEC - 1)) ? '0 : sel_idx + 1'b1;
    primed  = (warm_q == WCW'(LEAD));
    warm_en = !primed;
    warm_d  = warm_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_idx <= '0;
      warm_q  <= '0;
    end else begin
      sel_idx <= sel_d;
      if (warm_en) warm_q <= warm_d;
    end
  end

  // section sampling now is the one that transfers LEAD cycles later
  always_comb begin
    samp_sum = {1'b0, sel_idx} + (IDXW+1)'(LEAD % NSEC);
    if (samp_sum >= (IDXW+1)'(NSEC)) samp_sum = samp_sum - (IDXW+1)'(NSEC);
    samp_idx = samp_sum[IDXW-1:0];
  end

  for (genvar i = 0; i < NSEC; i++) begin : g_phase
    assign smp_onehot[i] = (samp_idx == IDXW'(i));
  end
endmodule

// File: rtl/irm_sec_mux.sv
`timescale 1ns/1ps
module irm_sec_mux #(
  parameter  int NSEC = irm_pkg::IRM_SECTIONS,
  parameter  int W    = irm_pkg::IRM_RES_W,
  localparam int IDXW = $clog2(NSEC)
) (
  input  logic [IDXW-1:0]   sel_idx,
  input  logic [NSEC*W-1:0] res_flat,
  input  logic [NSEC-1:0]   xfer,
  output logic [W-1:0]      res_sel,
  output logic              xfer_sel
);
  logic [NSEC-1:0] dec;

  for (genvar i = 0; i < NSEC; i++) begin : g_dec
    assign dec[i] = (sel_idx == IDXW'(i));
  end

  always_comb begin
    res_sel  = '0;
    xfer_sel = 1'b0;
    for (int i = 0; i < NSEC; i++) begin
      res_sel  = res_sel | (res_flat[i*W +: W] & {W{dec[i]}});
      xfer_sel = xfer_sel | (xfer[i] & dec[i]);
    end
  end
endmodule

// File: rtl/irm_ovr_fmt.sv
`timescale 1ns/1ps
module irm_ovr_fmt #(
  parameter int W = irm_pkg::IRM_RES_W
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] word
);
  // top bit flags overrange: clamp everything to ones
  always_comb begin
    if (raw[W-1]) word = '1;
    else          word = {1'b0, raw[W-2:0]};
  end
endmodule

// File: rtl/irm_result_merge.sv
`timescale 1ns/1ps
module irm_result_merge #(
  parameter int NSEC    = irm_pkg::IRM_SECTIONS,
  parameter int WRES    = irm_pkg::IRM_RES_W,
  parameter int LATENCY = irm_pkg::IRM_LATENCY
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 oe_n,
  input  logic [NSEC*WRES-1:0] sec_res,
  input  logic [NSEC-1:0]      sec_xfer,
  output logic [NSEC-1:0]      smp_phase,
  output logic [WRES-1:0]      dout,
  output logic                 dout_drive,
  output logic                 dval
);
  localparam int IDXW = $clog2(NSEC);
  localparam int LEAD = LATENCY - 1;

  logic [IDXW-1:0] sel_idx;
  logic            primed;
  logic [WRES-1:0] res_sel, word;
  logic            xfer_sel;
  logic [WRES-1:0] dout_d;
  logic            dval_d, cap_en;

  irm_phase_gen #(.NSEC(NSEC), .LEAD(LEAD)) u_phase (
    .clk(clk), .rst_n(rst_n), .sel_idx(sel_idx),
    .primed(primed), .smp_onehot(smp_phase)
  );

  irm_sec_mux #(.NSEC(NSEC), .W(WRES)) u_mux (
    .sel_idx(sel_idx), .res_flat(sec_res), .xfer(sec_xfer),
    .res_sel(res_sel), .xfer_sel(xfer_sel)
  );

  irm_ovr_fmt #(.W(WRES)) u_fmt (.raw(res_sel), .word(word));

  always_comb begin
    dval_d = primed & xfer_sel;
    cap_en = dval_d;
    dout_d = word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      dval <= 1'b0;
    end else begin
      dval <= dval_d;
      if (cap_en) dout <= dout_d;
    end
  end

  assign dout_drive = ~oe_n;
endmodule

// File: rtl/irm_result_merge_chk.sv
`timescale 1ns/1ps
module irm_result_merge_chk #(
  parameter int NSEC    = 16,
  parameter int WRES    = 9,
  parameter int LATENCY = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSEC-1:0] smp_phase,
  input logic [WRES-1:0] dout,
  input logic            dval
);
  localparam int CW = $clog2(LATENCY + 1);
  logic [CW-1:0]   cnt;
  logic [NSEC-1:0] prev_phase;
  logic            prev_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      prev_phase <= '0;
      prev_ok    <= 1'b0;
    end else begin
      if (cnt != CW'(LATENCY)) cnt <= cnt + 1'b1;
      prev_phase <= smp_phase;
      prev_ok    <= 1'b1;
    end
  end

  assert_phase_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(smp_phase) == 1);

  assert_phase_rotate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prev_ok |-> smp_phase == {prev_phase[NSEC-2:0], prev_phase[NSEC-1]});

  assert_warmup_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < CW'(LATENCY)) |-> !dval);

  assert_hold_no_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dval |-> $stable(dout));

  assert_overrange_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dval && dout[WRES-1]) |-> dout[WRES-2:0] == '1);
endmodule

bind irm_result_merge irm_result_merge_chk #(.NSEC(NSEC), .WRES(WRES), .LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_phase(smp_phase), .dout(dout), .dval(dval)
);

// File: tb/irm_result_merge_test.sv
`timescale 1ns/1ps
module irm_result_merge_test;
  localparam int NS = 16;
  localparam int W  = 9;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            oe_n;
  logic [NS*W-1:0] sec_res;
  logic [NS-1:0]   sec_xfer;
  logic [NS-1:0]   smp_phase;
  logic [W-1:0]    dout;
  logic            dout_drive;
  logic            dval;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [W-1:0] mem [NS];
  logic [W-1:0] last_out;

  irm_result_merge uut (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .sec_res(sec_res), .sec_xfer(sec_xfer),
    .smp_phase(smp_phase), .dout(dout), .dout_drive(dout_drive), .dval(dval)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc = 0;
    else        cyc = cyc + 1;
  end

  function automatic logic [W-1:0] fmt(input logic [W-1:0] v);
    return v[W-1] ? 9'h1FF : {1'b0, v[W-2:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic pack();
    for (int i = 0; i < NS; i++) sec_res[i*W +: W] = mem[i];
  endtask

  // one clock: drive at negedge, check at the following negedge
  task automatic tick(input bit own, input logic [NS-1:0] extra, input string tag);
    int p, c0;
    bit ev;
    logic [W-1:0] exp;
    p  = cyc % NS;
    c0 = cyc;
    pack();
    sec_xfer = (own ? (16'b1 << p) : 16'b0) | extra;
    @(posedge clk);
    @(negedge clk);
    ev  = (own || extra[p]) && (c0 >= 11);
    exp = ev ? fmt(mem[p]) : last_out;
    check(dval == ev, {tag, " dval"}, 16'(dval), 16'(ev));
    check(dout == exp, {tag, " dout"}, 16'(dout), 16'(exp));
    check(smp_phase == (16'b1 << ((cyc + 11) % NS)), "R2 phase", smp_phase, 16'b1 << ((cyc + 11) % NS));
    last_out = exp;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; oe_n = 1'b0; sec_xfer = '0;
    for (int i = 0; i < NS; i++) mem[i] = 9'(8'h10 + 8'(i * 7));
    pack();
    repeat (3) @(negedge clk);
    check(dout == 9'h0, "R1 dout in reset", 16'(dout), 16'h0);
    check(dval == 1'b0, "R1 dval in reset", 16'(dval), 16'h0);
    rst_n = 1'b1;
    #1;
    check(smp_phase == 16'h0800, "R1 phase after release", smp_phase, 16'h0800);
    last_out = '0;
  endtask

  task automatic t_warmup();
    for (int k = 0; k < 11; k++) tick(1'b1, '0, "R4 warmup");
    tick(1'b1, '0, "R4 first accepted");
    check(dval == 1'b1, "R4 first valid", 16'(dval), 16'h1);
  endtask

  task automatic t_binary();
    logic [W-1:0] vals [4] = '{9'h000, 9'h001, 9'h080, 9'h0FF};
    for (int k = 0; k < 4; k++) begin
      mem[cyc % NS] = vals[k];
      tick(1'b1, '0, "R7 binary");
      check(dout == {1'b0, vals[k][7:0]}, "R7 code", 16'(dout), 16'({1'b0, vals[k][7:0]}));
    end
  endtask

  task automatic t_overrange();
    logic [W-1:0] vals [3] = '{9'h100, 9'h1A5, 9'h17E};
    for (int k = 0; k < 3; k++) begin
      mem[cyc % NS] = vals[k];
      tick(1'b1, '0, "R8 overrange");
      check(dout == 9'h1FF, "R8 clamp", 16'(dout), 16'h1FF);
    end
  endtask

  task automatic t_nostrobe();
    logic [W-1:0] held;
    held = last_out;
    mem[cyc % NS] = ~held;
    tick(1'b0, '0, "R5 no strobe");
    check(dout == held, "R5 hold", 16'(dout), 16'(held));
  endtask

  task automatic t_foreign();
    logic [W-1:0] held;
    int p;
    held = last_out;
    p = cyc % NS;
    for (int i = 0; i < NS; i++) if (i != p) mem[i] = 9'h055 ^ 9'(i);
    tick(1'b0, ~(16'b1 << p), "R6 foreign strobes");
    check(dout == held && dval == 1'b0, "R6 ignored", 16'(dout), 16'(held));
  endtask

  task automatic t_latency();
    int s;
    s = -1;
    for (int i = 0; i < NS; i++) if (smp_phase[i]) s = i;
    check(s == (cyc + 11) % NS, "R3 sampling section", 16'(s), 16'((cyc + 11) % NS));
    mem[s] = 9'h0C3;
    for (int k = 0; k < 12; k++) tick(1'b1, '0, "R3 stream");
    check(dout == 9'h0C3 && dval, "R3 latency 12", 16'(dout), 16'h0C3);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < NS; i++) mem[i] = 9'(8'hA0 + 8'(i));
    while (cyc % NS != 15) tick(1'b1, '0, "R10 run");
    tick(1'b1, '0, "R10 index 15");
    check(dout == 9'h0AF, "R10 section 15", 16'(dout), 16'h0AF);
    tick(1'b1, '0, "R10 index 0");
    check(dout == 9'h0A0, "R10 wrap to 0", 16'(dout), 16'h0A0);
  endtask

  task automatic t_oe();
    oe_n = 1'b1;
    #1;
    check(dout_drive == 1'b0, "R9 drive off", 16'(dout_drive), 16'h0);
    mem[cyc % NS] = 9'h03C;
    tick(1'b1, '0, "R9 data while disabled");
    oe_n = 1'b0;
    #1;
    check(dout_drive == 1'b1, "R9 drive on", 16'(dout_drive), 16'h1);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_warmup();
    t_binary();
    t_overrange();
    t_nostrobe();
    t_foreign();
    t_latency();
    t_wrap();
    t_oe();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule